// File: doc/BRIEF.md
# Reconfigurable Johnson Counter

This block is a chain of flip-flops whose serial input is chosen by two control pins. The same chain can do three jobs. It can clear itself by pushing zeros through. It can count as a Johnson counter, feeding back the inverted last stage. It can also rotate its contents so that every stage in turn presents one codeword. In a low-power self-test pattern source, a controller steps the counter once to form a new single-input-change vector. It then switches to rotation for one full lap, so that the vector's rotations can be fed to several pattern consumers.

A wrapping vector index counts the steps taken in count mode. It lets the controller see when all 2·STAGES vectors of one Johnson period have been used. Stage 0 is the entry of the chain, and stage STAGES-1 is the last stage and the serial tap.

Top module: `sic_ring_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `state_q` becomes all zeros and `vec_idx` becomes 0, whatever the value of `clk_en`.
- R2: With `rst_n` high and `clk_en` low, a rising edge leaves `state_q` and `vec_idx` unchanged in every mode.
- R3: Fill mode (`shift_mode`=1, `rotate_sel`=0): each enabled edge moves stage i-1 into stage i and loads 0 into stage 0. After STAGES such edges every stage is 0.
- R4: Rotate mode (`shift_mode`=1, `rotate_sel`=1): each enabled edge moves stage i-1 into stage i and the old last stage into stage 0. After STAGES edges the original contents return.
- R5: Count mode (`shift_mode`=0): each enabled edge moves stage i-1 into stage i and loads the inverted old last stage into stage 0. Starting from all zeros, 2·STAGES steps visit 2·STAGES distinct vectors and then return to all zeros.
- R6: In count mode, starting from all zeros, every pair of consecutive vectors differs in exactly one bit.
- R7: `vec_idx` rises by one on each enabled count-mode edge and wraps from 2·STAGES-1 to 0. It holds in fill and rotate modes.
- R8: `serial_out` always equals the last stage, `state_q[STAGES-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Step enable; state moves only when high |
| shift_mode | input | 1 | 1 = fill or rotate, 0 = Johnson count |
| rotate_sel | input | 1 | With shift_mode=1: 1 = rotate, 0 = fill with zeros |
| state_q | output | STAGES | Current stage contents, bit 0 = entry stage |
| serial_out | output | 1 | Last stage tap |
| vec_idx | output | $clog2(2·STAGES) | Count-mode step index, wraps at 2·STAGES |

## Verification
A wrong feed choice shows on `state_q` bit 0 at the very next enabled edge: a 1 where fill should put a 0, or a copy of the last stage where count mode should put its inverse. A wrong shift link shows at the next edge in the bit above it. Errors in the index are visible one edge after the first count step, and a wrap fault is visible only after exactly 2·STAGES steps. The bench therefore runs full laps in every mode. Lost enable gating shows as a change on any idle edge.

// File: rtl/sic_ring_pkg.sv
// Shared types for the reconfigurable Johnson counter.
// Assumes: consumers import it before use.
package sic_ring_pkg;
    // Source chosen for the chain's serial input
    typedef enum logic [1:0] {
        FEED_ZERO   = 2'd0,
        FEED_LOOP   = 2'd1,
        FEED_INVERT = 2'd2
    } feed_sel_e;
endpackage

// File: rtl/sic_feed_mux.sv
// Chooses the serial input of the chain from the two mode pins.
// Assumes: last_bit is the current last stage; purely combinational.
module sic_feed_mux
    import sic_ring_pkg::*;
(
    input  logic      shift_mode,
    input  logic      rotate_sel,
    input  logic      last_bit,
    output feed_sel_e feed_sel,
    output logic      feed_bit
);
    // Decode the mode pins into a feed source
    always_comb begin
        if (!shift_mode)     feed_sel = FEED_INVERT;
        else if (rotate_sel) feed_sel = FEED_LOOP;
        else                 feed_sel = FEED_ZERO;
    end

    // Produce the bit for the selected source
    always_comb begin
        case (feed_sel)
            FEED_LOOP:   feed_bit = last_bit;
            FEED_INVERT: feed_bit = ~last_bit;
            default:     feed_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sic_stage_chain.sv
// STAGES-long shift chain: stage 0 takes feed_bit, stage i takes stage i-1.
// Assumes: STAGES >= 2; synchronous active-low reset overrides the enable.
module sic_stage_chain #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              feed_bit,
    output logic [STAGES-1:0] state_q
);
    logic [STAGES-1:0] next_d;

    // Wire each stage to its upstream neighbour
    assign next_d[0] = feed_bit;
    for (genvar g = 1; g < STAGES; g++) begin : g_link
        assign next_d[g] = state_q[g-1];
    end

    // One flop per stage, cleared by reset, gated by the enable
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)      state_q[g] <= 1'b0;
            else if (clk_en) state_q[g] <= next_d[g];
        end
    end
endmodule

// File: rtl/sic_vec_counter.sv
// Index of count-mode steps, wrapping after 2*STAGES steps.
// Assumes: step is high only on enabled count-mode edges.
module sic_vec_counter #(
    parameter int STAGES = 8,
    parameter int IDX_W  = $clog2(2 * STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx_q
);
    localparam int               PERIOD   = 2 * STAGES;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PERIOD - 1);

    // Advance on each step and wrap at the Johnson period
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (step) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
endmodule

// File: rtl/sic_ring_counter.sv
// Reconfigurable Johnson counter: zero fill, Johnson count or rotation,
// selected only through the serial input of one register chain.
// Assumes: STAGES >= 2; all controls synchronous to clk.
module sic_ring_counter
    import sic_ring_pkg::*;
#(
    parameter  int STAGES = 8,
    localparam int IDX_W  = $clog2(2 * STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              shift_mode,
    input  logic              rotate_sel,
    output logic [STAGES-1:0] state_q,
    output logic              serial_out,
    output logic [IDX_W-1:0]  vec_idx
);
    feed_sel_e feed_sel;
    logic      feed_bit;
    logic      count_step;

    sic_feed_mux u_feed (
        .shift_mode (shift_mode),
        .rotate_sel (rotate_sel),
        .last_bit   (state_q[STAGES-1]),
        .feed_sel   (feed_sel),
        .feed_bit   (feed_bit)
    );

    sic_stage_chain #(.STAGES(STAGES)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .feed_bit (feed_bit),
        .state_q  (state_q)
    );

    // Index advances only on enabled edges whose feed is the inverted tap
    assign count_step = clk_en && (feed_sel == FEED_INVERT);

    sic_vec_counter #(.STAGES(STAGES), .IDX_W(IDX_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (count_step),
        .idx_q (vec_idx)
    );

    // Serial tap is the last stage
    assign serial_out = state_q[STAGES-1];
endmodule

// File: rtl/sic_ring_counter_chk.sv
// Temporal checks on the counter's ports, bound to every instance.
// Assumes: STAGES >= 2.
module sic_ring_counter_chk #(
    parameter  int STAGES = 8,
    localparam int IDX_W  = $clog2(2 * STAGES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              shift_mode,
    input logic              rotate_sel,
    input logic [STAGES-1:0] state_q,
    input logic              serial_out,
    input logic [IDX_W-1:0]  vec_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2 * STAGES - 1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0 && vec_idx == '0)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clk_en) |=> ($stable(state_q) && $stable(vec_idx))); // R2

    AST_FILL_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clk_en && shift_mode && !rotate_sel) |=>
        (!state_q[0] && state_q[STAGES-1:1] == $past(state_q[STAGES-2:0]))); // R3

    AST_ROTATE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clk_en && shift_mode && rotate_sel) |=>
        (state_q == {$past(state_q[STAGES-2:0]), $past(state_q[STAGES-1])})); // R4

    AST_COUNT_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clk_en && !shift_mode) |=>
        (state_q[0] == !$past(state_q[STAGES-1]))); // R5

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clk_en && !shift_mode) |=>
        (vec_idx == (($past(vec_idx) == LAST_IDX) ? '0 : $past(vec_idx) + 1'b1))); // R7

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && shift_mode) |=> $stable(vec_idx)); // R7
endmodule

bind sic_ring_counter sic_ring_counter_chk #(.STAGES(STAGES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .shift_mode (shift_mode),
    .rotate_sel (rotate_sel),
    .state_q    (state_q),
    .serial_out (serial_out),
    .vec_idx    (vec_idx)
);

// File: tb/sic_ring_counter_tb_top.sv
`timescale 1ns/1ps
module sic_ring_counter_tb_top;
    localparam int L = 8;
    localparam int P = 2 * L;

    logic         clk = 1'b0;
    logic         rst_n, clk_en, shift_mode, rotate_sel;
    logic [L-1:0] state_q;
    logic         serial_out;
    logic [3:0]   vec_idx;
    int           errors = 0;
    int           checks = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    sic_ring_counter #(.STAGES(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .shift_mode(shift_mode),
        .rotate_sel(rotate_sel), .state_q(state_q), .serial_out(serial_out),
        .vec_idx(vec_idx)
    );

    // {rst_n, clk_en, shift_mode, rotate_sel, expected state, expected index}
    localparam logic [15:0] TBL [12] = '{
        {4'b0000, 8'h00, 4'd0},  // R1 reset
        {4'b1100, 8'h01, 4'd1},  // R5 count
        {4'b1100, 8'h03, 4'd2},  // R5
        {4'b1100, 8'h07, 4'd3},  // R5
        {4'b1000, 8'h07, 4'd3},  // R2 idle
        {4'b1111, 8'h0E, 4'd3},  // R4 rotate
        {4'b1111, 8'h1C, 4'd3},  // R4
        {4'b1100, 8'h39, 4'd4},  // R5 count from rotated word
        {4'b1110, 8'h72, 4'd4},  // R3 fill
        {4'b1111, 8'hE4, 4'd4},  // R4
        {4'b1111, 8'hC9, 4'd4},  // R4 last stage wraps to stage 0
        {4'b1110, 8'h92, 4'd4}   // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic m, input logic s);
        @(negedge clk);
        rst_n = r; clk_en = e; shift_mode = m; rotate_sel = s;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        logic [L-1:0] model;
        logic [L-1:0] prev;
        bit           seen [256];
        rst_n = 1'b0; clk_en = 1'b0; shift_mode = 1'b0; rotate_sel = 1'b0;

        // Table walk
        for (int i = 0; i < 12; i++) begin
            step(TBL[i][15], TBL[i][14], TBL[i][13], TBL[i][12]);
            chk($sformatf("R1/R2/R3/R4/R5 state row %0d", i), 32'(state_q), 32'(TBL[i][11:4]));
            chk($sformatf("R7 index row %0d", i), 32'(vec_idx), 32'(TBL[i][3:0]));
            chk("R8 serial tap", 32'(serial_out), 32'(state_q[L-1]));
        end

        // R1: reset clears even with enable low
        step(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R1 reset state", 32'(state_q), 32'h0);
        chk("R1 reset index", 32'(vec_idx), 32'h0);

        // R5/R6/R7: full Johnson period from zero
        for (int k = 0; k < 256; k++) seen[k] = 1'b0;
        seen[0] = 1'b1;
        model = '0;
        for (int k = 0; k < P; k++) begin
            prev = state_q;
            step(1'b1, 1'b1, 1'b0, 1'b0);
            model = {model[L-2:0], ~model[L-1]};
            chk("R5 count vector", 32'(state_q), 32'(model));
            chk("R6 single change", 32'($countones(state_q ^ prev)), 32'd1);
            chk("R7 index step", 32'(vec_idx), 32'((k + 1) % P));
            chk("R8 serial tap", 32'(serial_out), 32'(model[L-1]));
            if (k < P - 1) begin
                chk("R5 distinct vector", 32'(seen[state_q]), 32'd0);
                seen[state_q] = 1'b1;
            end
        end
        chk("R5 period return", 32'(state_q), 32'h0);

        // R3: fill from 1F clears after L steps
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, 1'b0);
        model = 8'h1F;
        chk("R5 preload", 32'(state_q), 32'(model));
        for (int k = 0; k < L; k++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0);
            model = {model[L-2:0], 1'b0};
            chk("R3 fill step", 32'(state_q), 32'(model));
            chk("R7 index held in fill", 32'(vec_idx), 32'd5);
        end
        chk("R3 cleared", 32'(state_q), 32'h0);

        // R4: rotate a Johnson word for one lap
        step(1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b0, 1'b0);
        model = 8'h0F;
        for (int k = 0; k < L; k++) begin
            step(1'b1, 1'b1, 1'b1, 1'b1);
            model = {model[L-2:0], model[L-1]};
            chk("R4 rotate step", 32'(state_q), 32'(model));
            chk("R8 serial tap", 32'(serial_out), 32'(model[L-1]));
        end
        chk("R4 lap returns", 32'(state_q), 32'h0F);
        chk("R7 index held in rotate", 32'(vec_idx), 32'd4);

        // R2: idle in each mode on a non-zero word
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R2 idle fill", 32'(state_q), 32'h0F);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 idle count state", 32'(state_q), 32'h0F);
        chk("R2 idle count index", 32'(vec_idx), 32'd4);

        done = 1'b1;
        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule